// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator with Dead Time

This block drives the six gate signals of a three-phase bridge for a 120-degree (block-commutated) DC motor. A free-running carrier counter sets a common PWM period. Each of the six gates compares the counter against a duty threshold. Each gate has two thresholds, and the commutation sector input chooses which of the two applies. This lets the controller set up the duties for the next half of the electrical cycle ahead of time.

Each phase has an upper gate and a lower gate, and the two are never driven together. The lower gate must have been off for a programmable number of cycles before the upper gate may turn on. A second, separate count sets the same wait before the lower gate turns on. The period and duty thresholds are written through a simple register port into shadow copies. These copies take effect only at the carrier wrap, so each period runs with one consistent setting. Setting a duty of zero or of full scale holds a gate steadily off or on. Each phase can therefore run chopped PWM or plain rectangular drive.

Top module: `tpwm_gen`

## Requirements
- R1: The carrier counter counts 0,1,...,P and then returns to 0, where P is the active period value, so one carrier period lasts P+1 clock cycles.
- R2: A gate requests to be active in a cycle when the counter value is below its selected threshold. The gate output is registered and follows the counter by one clock.
- R3: Write address 0 holds the period, and addresses 1 to 12 hold thresholds. For phase p (0=U, 1=V, 2=W), the upper gate gate_o[2p] uses address 4p+1 in sectors 0–2 and address 4p+2 in sectors 3–7. The lower gate gate_o[2p+1] uses address 4p+3 in sectors 0–2 and address 4p+4 in sectors 3–7.
- R4: A threshold of 0 keeps its gate off for the whole period. A threshold of P+1 or more keeps the gate requested for the whole period, and while its partner is not requested the gate stays on without any dead-time break.
- R5: After the lower gate of a phase turns off, the upper gate turns on only after both gates have been off for max(1, DU) clock cycles, where DU is written at address 13.
- R6: After the upper gate of a phase turns off, the lower gate turns on only after both gates have been off for max(1, DL) clock cycles, where DL is written at address 14.
- R7: The two gates of a phase are never on in the same cycle. When both are requested, the upper request wins and the lower gate is turned off.
- R8: Period and threshold writes go to shadow registers. These are copied to the active registers on the clock edge where the counter goes from P to 0, and on every clock edge while the block is disabled. The dead-time counts at addresses 13 and 14 take effect on the edge after the write. They are written from the low 8 bits of the data.
- R9: While en is low, all six gates are off from the next clock edge. The counter is held at 0, and the off-time counts of all phases restart from zero.
- R10: A synchronous reset clears all registers to 0 and turns all gates off.
- R11: A write to address 15 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces all gates off |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0 period, 1–12 thresholds, 13/14 dead times) |
| wr_data | input | CW | Register write data |
| sector | input | 3 | Commutation sector, selects the threshold set |
| gate_o | output | 6 | Gates: [2p] upper and [2p+1] lower of phase p |

## Verification
The hardest cases to reach are the ones where several events happen at once. One is a write that arrives on the very cycle the counter wraps, which must still leave the old shadow value for that copy. Another is a phase whose upper and lower requests overlap, or switch just as the dead-time wait ends. The random stimulus writes to any address on any cycle, keeps periods short, and draws thresholds from a range that crosses P+1. It also flips the sector and enable at random, so these coincidences happen many times. Directed cases measure the off gaps and the carrier period in clock cycles at the gate pins.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
  localparam int unsigned NPH  = 3;
  localparam int unsigned NCMP = 4 * NPH;
  localparam int unsigned AW   = 4;
  localparam logic [AW-1:0] ADDR_PERIOD = 4'd0;
  localparam logic [AW-1:0] ADDR_DT_UP  = 4'd13;
  localparam logic [AW-1:0] ADDR_DT_LO  = 4'd14;
  // first sector that selects the second threshold of each pin
  localparam logic [2:0] SECTOR_SPLIT = 3'd3;
endpackage

// File: rtl/tpwm_regs.sv
module tpwm_regs
  import tpwm_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          load,
  output logic [CW-1:0] per_a,
  output logic [CW-1:0] cmp_a [NCMP],
  output logic [DW-1:0] dt_up,
  output logic [DW-1:0] dt_lo
);
  logic [CW-1:0] per_s;
  logic [CW-1:0] cmp_s [NCMP];

  always_ff @(posedge clk) begin
    if (rst) begin
      per_s <= '0;
      per_a <= '0;
      dt_up <= '0;
      dt_lo <= '0;
    end else begin
      if (wr_en && wr_addr == ADDR_PERIOD) per_s <= wr_data;
      if (wr_en && wr_addr == ADDR_DT_UP)  dt_up <= wr_data[DW-1:0];
      if (wr_en && wr_addr == ADDR_DT_LO)  dt_lo <= wr_data[DW-1:0];
      if (load) per_a <= per_s;
    end
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_s[i] <= '0;
        cmp_a[i] <= '0;
      end else begin
        if (wr_en && wr_addr == AW'(i + 1)) cmp_s[i] <= wr_data;
        if (load) cmp_a[i] <= cmp_s[i];
      end
    end
  end

  // R8: active period only moves on a load edge
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(per_a));
endmodule

// File: rtl/tpwm_carrier.sv
module tpwm_carrier #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt,
  output logic          load
);
  logic wrap;
  assign wrap = en && (cnt == period);
  assign load = !en || wrap;

  always_ff @(posedge clk) begin
    if (rst || !en || wrap) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // R1: counter never passes the active period
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= period);
  // R9: disabled counter sits at zero
  a_r9_cnt_clear: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt == '0);
endmodule

// File: rtl/tpwm_dead.sv
module tpwm_dead #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          want_up,
  input  logic          want_lo,
  input  logic [DW-1:0] dt_up,
  input  logic [DW-1:0] dt_lo,
  output logic          gate_up,
  output logic          gate_lo
);
  localparam logic [DW-1:0] IDLE_MAX = '1;

  logic [DW-1:0] idle;   // cycles both gates have been off
  logic          nxt_up, nxt_lo, can_up, can_lo;

  assign can_up = !gate_lo && (idle != '0) && (idle >= dt_up);
  assign can_lo = !gate_up && (idle != '0) && (idle >= dt_lo);
  assign nxt_up = en && want_up && (gate_up || can_up);
  assign nxt_lo = en && want_lo && !want_up && (gate_lo || can_lo);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      gate_up <= 1'b0;
      gate_lo <= 1'b0;
      idle    <= '0;
    end else begin
      gate_up <= nxt_up;
      gate_lo <= nxt_lo;
      if (nxt_up || nxt_lo)   idle <= '0;
      else if (idle != IDLE_MAX) idle <= idle + 1'b1;
    end
  end

  // R7: pair exclusive
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(gate_up && gate_lo));
  // R5: upper rises only after lower was already off
  a_r5_up_after_lo: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_up) |-> $past(!gate_lo));
  // R6: lower rises only after upper was already off
  a_r6_lo_after_up: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_lo) |-> $past(!gate_up));
  // R9: disable turns the pair off
  a_r9_pair_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> !gate_up && !gate_lo);
endmodule

// File: rtl/tpwm_gen.sv
module tpwm_gen
  import tpwm_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [2:0]    sector,
  output logic [5:0]    gate_o
);
  logic [CW-1:0] per_a;
  logic [CW-1:0] cmp_a [NCMP];
  logic [DW-1:0] dt_up, dt_lo;
  logic [CW-1:0] cnt;
  logic          load;
  logic          second;

  assign second = (sector >= SECTOR_SPLIT);

  tpwm_regs #(.CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(load), .per_a(per_a), .cmp_a(cmp_a),
    .dt_up(dt_up), .dt_lo(dt_lo)
  );

  tpwm_carrier #(.CW(CW)) u_carrier (
    .clk(clk), .rst(rst), .en(en), .period(per_a), .cnt(cnt), .load(load)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic [CW-1:0] thr_up, thr_lo;
    logic          want_up, want_lo;
    assign thr_up  = second ? cmp_a[4*p+1] : cmp_a[4*p];
    assign thr_lo  = second ? cmp_a[4*p+3] : cmp_a[4*p+2];
    assign want_up = cnt < thr_up;
    assign want_lo = cnt < thr_lo;

    tpwm_dead #(.DW(DW)) u_dead (
      .clk(clk), .rst(rst), .en(en), .want_up(want_up), .want_lo(want_lo),
      .dt_up(dt_up), .dt_lo(dt_lo),
      .gate_up(gate_o[2*p]), .gate_lo(gate_o[2*p+1])
    );
  end

  // R4: a zero threshold in both sets keeps the upper gate of U off
  a_r4_zero_off: assert property (@(posedge clk) disable iff (rst)
    (cmp_a[0] == '0 && cmp_a[1] == '0 && $past(cmp_a[0] == '0 && cmp_a[1] == '0))
      |-> !gate_o[0]);
endmodule

// File: tb/tb_tpwm_gen.sv
module tb_tpwm_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [2:0]    sector = '0;
  logic [5:0]    gate_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  string cur_req = "R10";

  tpwm_gen #(.CW(CW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sector(sector), .gate_o(gate_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model from the requirements ----------------
  int m_cnt, m_per_a, m_per_s, m_dtu, m_dtl;
  int m_cmp_a [12];
  int m_cmp_s [12];
  int m_idle [3];
  logic [5:0] m_g;

  function automatic int max1(int v);
    return (v < 1) ? 1 : v;
  endfunction

  // returns {upper_next, lower_next} for one phase
  function automatic logic [1:0] pair_next(logic wu, logic wl, logic gu, logic gl,
                                           int idle, int du, int dl);
    logic nu, nl;
    nu = wu && (gu || (!gl && idle >= max1(du)));
    nl = wl && !wu && (gl || (!gu && idle >= max1(dl)));
    return {nu, nl};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_per_a = 0; m_per_s = 0; m_dtu = 0; m_dtl = 0; m_g = '0;
      for (int i = 0; i < 12; i++) begin m_cmp_a[i] = 0; m_cmp_s[i] = 0; end
      for (int p = 0; p < 3; p++) m_idle[p] = 0;
    end else begin
      int sel;
      logic ld;
      sel = (sector >= 3) ? 1 : 0;
      for (int p = 0; p < 3; p++) begin
        logic [1:0] nx;
        if (!en) begin
          nx = 2'b00; m_idle[p] = 0;
        end else begin
          nx = pair_next(m_cnt < m_cmp_a[4*p+sel], m_cnt < m_cmp_a[4*p+2+sel],
                         m_g[2*p], m_g[2*p+1], m_idle[p], m_dtu, m_dtl);
          if (nx != 2'b00) m_idle[p] = 0;
          else if (m_idle[p] < 255) m_idle[p]++;
        end
        m_g[2*p] = nx[1];
        m_g[2*p+1] = nx[0];
      end
      ld = !en || (m_cnt == m_per_a);
      m_cnt = (!en || m_cnt == m_per_a) ? 0 : m_cnt + 1;
      if (ld) begin
        m_per_a = m_per_s;
        for (int i = 0; i < 12; i++) m_cmp_a[i] = m_cmp_s[i];
      end
      if (wr_en) begin
        if (wr_addr == 0) m_per_s = int'(wr_data);
        else if (wr_addr <= 12) m_cmp_s[wr_addr-1] = int'(wr_data);
        else if (wr_addr == 13) m_dtu = int'(wr_data[7:0]);
        else if (wr_addr == 14) m_dtl = int'(wr_data[7:0]);
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(string req, int act, int exp, string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    check(cur_req, int'(gate_o), int'(m_g), "gate_o");
    if (gate_o[0] && gate_o[1] || gate_o[2] && gate_o[3] || gate_o[4] && gate_o[5])
      check("R7", int'(gate_o), 0, "pair overlap");
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = CW'(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic clear_cmp();
    for (int i = 1; i <= 12; i++) wr(i, 0);
  endtask

  // count negedges while both gates of phase U are off, between an upper
  // fall and the following lower rise
  task automatic gap_up_to_lo(int exp);
    int g;
    int guard;
    g = 0; guard = 0;
    while (!gate_o[0] && guard < 100) begin tick(); guard++; end
    while (gate_o[0] && guard < 200) begin tick(); guard++; end
    while (!gate_o[1] && guard < 300) begin g++; tick(); guard++; end
    check("R6", g, exp, "upper-to-lower gap");
  endtask

  task automatic gap_lo_to_up(int exp);
    int g;
    int guard;
    g = 0; guard = 0;
    while (!gate_o[1] && guard < 100) begin tick(); guard++; end
    while (gate_o[1] && guard < 200) begin tick(); guard++; end
    while (!gate_o[0] && guard < 300) begin g++; tick(); guard++; end
    check("R5", g, exp, "lower-to-upper gap");
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'h5eed_1234));
    cur_req = "R10";
    ticks(3);
    check("R10", int'(gate_o), 0, "reset gates");
    rst = 1'b0;
    ticks(2);
    check("R10", int'(gate_o), 0, "gates after reset");

    // R1/R2: period 9, U upper threshold 4
    cur_req = "R2";
    wr(0, 9); wr(1, 4); wr(13, 0); wr(14, 0);
    en = 1'b1;
    ticks(40);
    // R1: period measured between rises of a 1-cycle pulse
    cur_req = "R1";
    wr(1, 1);
    ticks(25);
    begin
      int per;
      int guard;
      per = 0; guard = 0;
      while (!gate_o[0] && guard < 50) begin tick(); guard++; end
      tick();
      while (!gate_o[0] && guard < 100) begin per++; tick(); guard++; end
      check("R1", per + 1, 10, "carrier period in cycles");
    end

    // R3: sector chooses second threshold set
    cur_req = "R3";
    wr(2, 7); wr(6, 3); wr(12, 5); wr(9, 2);
    sector = 3'd4;
    ticks(30);
    sector = 3'd1;
    ticks(30);
    sector = 3'd7;
    ticks(30);

    // R4: 0% and 100%
    cur_req = "R4";
    sector = 3'd0;
    clear_cmp();
    wr(1, 10); wr(5, 20);
    ticks(30);
    begin
      int hi;
      hi = 0;
      for (int i = 0; i < 10; i++) begin tick(); if (gate_o[0] && gate_o[2]) hi++; end
      check("R4", hi, 10, "full-duty cycles per period");
      check("R4", int'(gate_o[5:4]), 0, "zero-duty phase W");
    end

    // R5/R6: dead-time gaps on phase U
    cur_req = "R6";
    clear_cmp();
    wr(13, 2); wr(14, 3);
    wr(1, 5); wr(3, 10);
    ticks(20);
    gap_up_to_lo(3);
    cur_req = "R5";
    gap_lo_to_up(2);
    wr(13, 0); wr(14, 0);
    ticks(20);
    gap_lo_to_up(1);
    cur_req = "R6";
    gap_up_to_lo(1);

    // R7: both fully requested: upper wins
    cur_req = "R7";
    wr(1, 15); wr(3, 15);
    ticks(25);
    check("R7", int'(gate_o[1:0]), 1, "upper priority");

    // R8: shadow write mid-period takes effect at wrap
    cur_req = "R8";
    wr(1, 3); wr(3, 0);
    ticks(20);
    while (gate_o[0]) tick();
    wr(1, 8);
    check("R8", int'(gate_o[0]), 0, "shadow not yet active");
    ticks(30);
    wr(0, 5);
    ticks(30);

    // R11: address 15 ignored
    cur_req = "R11";
    wr(15, 16'h0003);
    ticks(20);

    // R9: disable
    cur_req = "R9";
    wr(1, 20);
    ticks(15);
    en = 1'b0;
    tick();
    check("R9", int'(gate_o), 0, "disabled gates");
    ticks(5);
    en = 1'b1;
    ticks(20);

    // random mix
    cur_req = "R2";
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 15) begin
        int a;
        a = int'($urandom_range(0, 15));
        wr_en = 1'b1; wr_addr = 4'(a);
        if (a == 0) wr_data = CW'($urandom_range(3, 16));
        else if (a >= 13) wr_data = CW'($urandom_range(0, 5));
        else wr_data = CW'($urandom_range(0, 20));
      end else begin
        wr_en = 1'b0;
      end
      if (r == 20) sector = 3'($urandom_range(0, 7));
      if (r == 21) en = ~en;
      if (r == 22) en = 1'b1;
      tick();
    end
    wr_en = 1'b0;
    ticks(5);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule